// File: doc/BRIEF.md
# Per-Flow Deadline and Eligibility Stamper

This block sits in the transmit side of a host network adapter and gives every outgoing packet a delivery deadline and an earliest-injection time. It keeps a small table with one entry per flow. Each entry holds the flow's mode, an increment value, a smoothing flag and the deadline most recently issued. A stamping request names a flow and supplies the packet length, the present time and, for frame-based flows, the number of packets the current frame breaks into. Two cycles later the block returns the new deadline, the eligible time and the flow's smoothing flag. It also records the new deadline as the flow's last deadline.

Rate-mode flows store a time-per-byte increment, and the deadline advances by length times that value. A control flow is simply a rate flow whose increment corresponds to full link speed. Frame-mode flows store a per-frame latency target, and the target is shared evenly across the packets of the frame. A separate combinational probe tells the transmit queue whether a queued packet may be injected yet. The eligible time stays inside the host and never enters the packet header.

Top module: `deadline_stamper`

## Requirements
- R1: After reset, rsp_valid is low, and every flow entry is in rate mode with increment 0, smoothing off and last deadline 0.
- R2: A request sampled on clock edge k yields rsp_valid with its results after edge k+2. In rate mode (cfg_frame=0) the deadline is base + req_len*increment, truncated to 32 bits.
- R3: The base is the later of the flow's stored last deadline and req_now. After each response the issued deadline becomes that flow's last deadline, so a deadline never falls before the request time.
- R4: In frame mode (cfg_frame=1) the increment is floor(target / req_parts), and a req_parts of 0 is treated as 1.
- R5: rsp_eligible equals rsp_deadline minus the parameter ELIG_FACTOR (default 20). rsp_smooth and rsp_flow echo the flow's smoothing flag and index.
- R6: chk_ok is 1 when chk_smooth is 0. When chk_smooth is 1, chk_ok is 1 only if chk_now + ELIG_FACTOR is not earlier than chk_deadline.
- R7: Every time comparison is wrap-safe: a is later than b when (a - b), taken as a 32-bit signed value, is positive.
- R8: A write with cfg_we loads mode, increment, smoothing flag and cfg_seed as the last deadline into entry cfg_flow. It leaves the other entries unchanged.
- R9: If a write lands on the same edge as the deadline update of the same flow, the written seed is kept. The response of that request is still issued with its own deadline.
- R10: Requests to one flow on consecutive cycles chain correctly: each one uses the deadline issued to the one before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one flow-table entry |
| cfg_flow | input | 4 | Entry index for the write |
| cfg_frame | input | 1 | 1 = frame mode, 0 = rate mode |
| cfg_smooth | input | 1 | Smoothing (eligibility check) enable |
| cfg_incr | input | 24 | Time per byte (rate) or per-frame latency target (frame) |
| cfg_seed | input | 32 | Initial last deadline |
| req_valid | input | 1 | Stamping request |
| req_flow | input | 4 | Flow of the packet |
| req_len | input | 16 | Packet length in bytes |
| req_now | input | 32 | Current time |
| req_parts | input | 8 | Packets in the current frame (frame mode) |
| rsp_valid | output | 1 | Stamp result valid |
| rsp_flow | output | 4 | Flow of the result |
| rsp_deadline | output | 32 | New deadline |
| rsp_eligible | output | 32 | Earliest injection time |
| rsp_smooth | output | 1 | Flow's smoothing flag |
| chk_now | input | 32 | Time for the eligibility probe |
| chk_deadline | input | 32 | Deadline of the queued packet |
| chk_smooth | input | 1 | Queued packet is smoothed |
| chk_ok | output | 1 | Packet may be injected now |

## Verification
Two functions can fall on the same edge: a table write from the configuration port, and the deadline write-back of a request in its second stage, both aimed at the same flow. The bench provokes this by issuing a request and driving a write to that flow on the very next cycle. The response must still carry the deadline computed from the old state. A later request to that flow must chain from the written seed rather than from the just-issued deadline. Back-to-back requests to one flow, and time values that straddle the 32-bit wrap, are judged in the same scoreboard.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  typedef enum logic {
    MODE_RATE  = 1'b0,
    MODE_FRAME = 1'b1
  } stamp_mode_e;
endpackage

// File: rtl/stamp_flow_table.sv
module stamp_flow_table #(
  parameter int FLOWS = 16,
  parameter int TW    = 32,
  parameter int INCW  = 24,
  parameter int FW    = $clog2(FLOWS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [FW-1:0]          cfg_flow,
  input  stamp_pkg::stamp_mode_e cfg_mode,
  input  logic                   cfg_smooth,
  input  logic [INCW-1:0]        cfg_incr,
  input  logic [TW-1:0]          cfg_seed,
  input  logic [FW-1:0]          rd_flow,
  output stamp_pkg::stamp_mode_e rd_mode,
  output logic                   rd_smooth,
  output logic [INCW-1:0]        rd_incr,
  input  logic                   upd_en,
  input  logic [FW-1:0]          upd_flow,
  input  logic [TW-1:0]          upd_deadline,
  input  logic [FW-1:0]          last_flow,
  output logic [TW-1:0]          last_deadline
);
  import stamp_pkg::*;

  stamp_mode_e       mode_q   [FLOWS];
  logic              smooth_q [FLOWS];
  logic [INCW-1:0]   incr_q   [FLOWS];
  logic [TW-1:0]     last_q   [FLOWS];
  logic [TW-1:0]     last_d   [FLOWS];
  logic [FLOWS-1:0]  cfg_hit;
  logic [FLOWS-1:0]  last_en;

  // next-state: configuration write has priority over the chain update
  always_comb begin
    for (int f = 0; f < FLOWS; f++) begin
      cfg_hit[f] = cfg_we && (cfg_flow == FW'(f));
      last_en[f] = cfg_hit[f] || (upd_en && (upd_flow == FW'(f)));
      last_d[f]  = cfg_hit[f] ? cfg_seed : upd_deadline;
    end
  end

  generate
    for (genvar g = 0; g < FLOWS; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q[g]   <= MODE_RATE;
          smooth_q[g] <= 1'b0;
          incr_q[g]   <= '0;
        end else if (cfg_hit[g]) begin
          mode_q[g]   <= cfg_mode;
          smooth_q[g] <= cfg_smooth;
          incr_q[g]   <= cfg_incr;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          last_q[g] <= '0;
        end else if (last_en[g]) begin
          last_q[g] <= last_d[g];
        end
      end
    end
  endgenerate

  assign rd_mode       = mode_q[rd_flow];
  assign rd_smooth     = smooth_q[rd_flow];
  assign rd_incr       = incr_q[rd_flow];
  assign last_deadline = last_q[last_flow];

  // R8: a write leaves its seed in the addressed entry
  a_r8_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> last_q[$past(cfg_flow)] == $past(cfg_seed));

  // R3: an uncontested update stores the issued deadline
  a_r3_chain_store: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(cfg_we && cfg_flow == upd_flow))
      |=> last_q[$past(upd_flow)] == $past(upd_deadline));
endmodule

// File: rtl/stamp_increment.sv
module stamp_increment #(
  parameter int FLOWS = 16,
  parameter int TW    = 32,
  parameter int LW    = 16,
  parameter int INCW  = 24,
  parameter int PW    = 8,
  parameter int FW    = $clog2(FLOWS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [FW-1:0]          req_flow,
  input  logic [LW-1:0]          req_len,
  input  logic [TW-1:0]          req_now,
  input  logic [PW-1:0]          req_parts,
  input  stamp_pkg::stamp_mode_e rd_mode,
  input  logic                   rd_smooth,
  input  logic [INCW-1:0]        rd_incr,
  output logic                   s_valid,
  output logic [FW-1:0]          s_flow,
  output logic [TW-1:0]          s_now,
  output logic [TW-1:0]          s_inc,
  output logic                   s_smooth
);
  import stamp_pkg::*;

  localparam int PRW = LW + INCW;

  logic [PRW-1:0]  prod;
  logic [PW-1:0]   den;
  logic [PW:0]     rem;
  logic [INCW-1:0] quo;
  logic [TW-1:0]   inc_d;

  // rate mode: length times per-byte time
  assign prod = PRW'(req_len) * PRW'(rd_incr);

  // frame mode: restoring division of the target by the packet count
  assign den = (req_parts == '0) ? PW'(1) : req_parts;

  always_comb begin
    rem = '0;
    quo = '0;
    for (int i = INCW - 1; i >= 0; i--) begin
      rem = {rem[PW-1:0], rd_incr[i]};
      if (rem >= {1'b0, den}) begin
        rem    = rem - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
  end

  assign inc_d = (rd_mode == MODE_FRAME) ? TW'(quo) : TW'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_valid <= 1'b0;
    else        s_valid <= req_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_flow   <= '0;
      s_now    <= '0;
      s_inc    <= '0;
      s_smooth <= 1'b0;
    end else if (req_valid) begin
      s_flow   <= req_flow;
      s_now    <= req_now;
      s_inc    <= inc_d;
      s_smooth <= rd_smooth;
    end
  end

  // R4: the frame share is the floor quotient of target by count
  a_r4_quotient_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && rd_mode == MODE_FRAME)
      |=> ((INCW+PW)'(s_inc) * (INCW+PW)'($past(den)) <= (INCW+PW)'($past(rd_incr)))
       && (((INCW+PW)'(s_inc) + 1) * (INCW+PW)'($past(den)) > (INCW+PW)'($past(rd_incr))));
endmodule

// File: rtl/stamp_chain.sv
module stamp_chain #(
  parameter int FLOWS       = 16,
  parameter int TW          = 32,
  parameter int ELIG_FACTOR = 20,
  parameter int FW          = $clog2(FLOWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  input  logic [FW-1:0] s_flow,
  input  logic [TW-1:0] s_now,
  input  logic [TW-1:0] s_inc,
  input  logic          s_smooth,
  input  logic [TW-1:0] last_deadline,
  output logic          upd_en,
  output logic [FW-1:0] upd_flow,
  output logic [TW-1:0] upd_deadline,
  output logic          rsp_valid,
  output logic [FW-1:0] rsp_flow,
  output logic [TW-1:0] rsp_deadline,
  output logic [TW-1:0] rsp_eligible,
  output logic          rsp_smooth
);
  logic signed [TW-1:0] gap;
  logic [TW-1:0]        base;
  logic [TW-1:0]        dl_d;

  // wrap-safe: now is later than last when the signed gap is positive
  assign gap          = $signed(s_now - last_deadline);
  assign base         = (gap > 0) ? s_now : last_deadline;
  assign dl_d         = base + s_inc;
  assign upd_en       = s_valid;
  assign upd_flow     = s_flow;
  assign upd_deadline = dl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= s_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_flow     <= '0;
      rsp_deadline <= '0;
      rsp_eligible <= '0;
      rsp_smooth   <= 1'b0;
    end else if (s_valid) begin
      rsp_flow     <= s_flow;
      rsp_deadline <= dl_d;
      rsp_eligible <= dl_d - TW'(ELIG_FACTOR);
      rsp_smooth   <= s_smooth;
    end
  end
endmodule

// File: rtl/stamp_elig_check.sv
module stamp_elig_check #(
  parameter int TW          = 32,
  parameter int ELIG_FACTOR = 20
) (
  input  logic [TW-1:0] chk_now,
  input  logic [TW-1:0] chk_deadline,
  input  logic          chk_smooth,
  output logic          chk_ok
);
  logic [TW-1:0]        horizon;
  logic signed [TW-1:0] slack;

  assign horizon = chk_now + TW'(ELIG_FACTOR);
  assign slack   = $signed(horizon - chk_deadline);
  assign chk_ok  = !chk_smooth || (slack >= 0);
endmodule

// File: rtl/deadline_stamper.sv
module deadline_stamper #(
  parameter int FLOWS       = 16,
  parameter int TW          = 32,
  parameter int LW          = 16,
  parameter int INCW        = 24,
  parameter int PW          = 8,
  parameter int ELIG_FACTOR = 20,
  parameter int FW          = $clog2(FLOWS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [FW-1:0]   cfg_flow,
  input  logic            cfg_frame,
  input  logic            cfg_smooth,
  input  logic [INCW-1:0] cfg_incr,
  input  logic [TW-1:0]   cfg_seed,
  input  logic            req_valid,
  input  logic [FW-1:0]   req_flow,
  input  logic [LW-1:0]   req_len,
  input  logic [TW-1:0]   req_now,
  input  logic [PW-1:0]   req_parts,
  output logic            rsp_valid,
  output logic [FW-1:0]   rsp_flow,
  output logic [TW-1:0]   rsp_deadline,
  output logic [TW-1:0]   rsp_eligible,
  output logic            rsp_smooth,
  input  logic [TW-1:0]   chk_now,
  input  logic [TW-1:0]   chk_deadline,
  input  logic            chk_smooth,
  output logic            chk_ok
);
  import stamp_pkg::*;

  stamp_mode_e     cfg_mode;
  stamp_mode_e     rd_mode;
  logic            rd_smooth;
  logic [INCW-1:0] rd_incr;
  logic            s_valid;
  logic [FW-1:0]   s_flow;
  logic [TW-1:0]   s_now;
  logic [TW-1:0]   s_inc;
  logic            s_smooth;
  logic [TW-1:0]   last_deadline;
  logic            upd_en;
  logic [FW-1:0]   upd_flow;
  logic [TW-1:0]   upd_deadline;

  assign cfg_mode = cfg_frame ? MODE_FRAME : MODE_RATE;

  stamp_flow_table #(.FLOWS(FLOWS), .TW(TW), .INCW(INCW)) u_table (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_mode(cfg_mode),
    .cfg_smooth(cfg_smooth), .cfg_incr(cfg_incr), .cfg_seed(cfg_seed),
    .rd_flow(req_flow), .rd_mode(rd_mode), .rd_smooth(rd_smooth), .rd_incr(rd_incr),
    .upd_en(upd_en), .upd_flow(upd_flow), .upd_deadline(upd_deadline),
    .last_flow(s_flow), .last_deadline(last_deadline)
  );

  stamp_increment #(.FLOWS(FLOWS), .TW(TW), .LW(LW), .INCW(INCW), .PW(PW)) u_incr (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_flow(req_flow), .req_len(req_len),
    .req_now(req_now), .req_parts(req_parts),
    .rd_mode(rd_mode), .rd_smooth(rd_smooth), .rd_incr(rd_incr),
    .s_valid(s_valid), .s_flow(s_flow), .s_now(s_now), .s_inc(s_inc), .s_smooth(s_smooth)
  );

  stamp_chain #(.FLOWS(FLOWS), .TW(TW), .ELIG_FACTOR(ELIG_FACTOR)) u_chain (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_flow(s_flow), .s_now(s_now), .s_inc(s_inc), .s_smooth(s_smooth),
    .last_deadline(last_deadline),
    .upd_en(upd_en), .upd_flow(upd_flow), .upd_deadline(upd_deadline),
    .rsp_valid(rsp_valid), .rsp_flow(rsp_flow), .rsp_deadline(rsp_deadline),
    .rsp_eligible(rsp_eligible), .rsp_smooth(rsp_smooth)
  );

  stamp_elig_check #(.TW(TW), .ELIG_FACTOR(ELIG_FACTOR)) u_check (
    .chk_now(chk_now), .chk_deadline(chk_deadline),
    .chk_smooth(chk_smooth), .chk_ok(chk_ok)
  );

  // R2: every request produces a response two edges later
  a_r2_rsp_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ##2 rsp_valid);

  // R3: an issued deadline is never before the request time
  a_r3_no_backstep: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid, 2)) |-> ($signed(rsp_deadline - $past(req_now, 2)) >= 0));
endmodule

// File: tb/deadline_stamper_tb.sv
`timescale 1ns/1ps
module deadline_stamper_tb;
  localparam int EF = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_frame, cfg_smooth;
  logic [3:0]  cfg_flow;
  logic [23:0] cfg_incr;
  logic [31:0] cfg_seed;
  logic        req_valid;
  logic [3:0]  req_flow;
  logic [15:0] req_len;
  logic [31:0] req_now;
  logic [7:0]  req_parts;
  logic        rsp_valid, rsp_smooth;
  logic [3:0]  rsp_flow;
  logic [31:0] rsp_deadline, rsp_eligible;
  logic [31:0] chk_now, chk_deadline;
  logic        chk_smooth, chk_ok;

  always #4 clk = ~clk;

  deadline_stamper #(.ELIG_FACTOR(EF)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_flow(cfg_flow), .cfg_frame(cfg_frame), .cfg_smooth(cfg_smooth),
    .cfg_incr(cfg_incr), .cfg_seed(cfg_seed),
    .req_valid(req_valid), .req_flow(req_flow), .req_len(req_len),
    .req_now(req_now), .req_parts(req_parts),
    .rsp_valid(rsp_valid), .rsp_flow(rsp_flow), .rsp_deadline(rsp_deadline),
    .rsp_eligible(rsp_eligible), .rsp_smooth(rsp_smooth),
    .chk_now(chk_now), .chk_deadline(chk_deadline), .chk_smooth(chk_smooth), .chk_ok(chk_ok)
  );

  typedef struct {
    logic [3:0]  flow;
    logic [31:0] dl;
    logic        sm;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  // bench model of the flow table
  bit          m_frame [16];
  bit          m_smooth[16];
  logic [23:0] m_incr  [16];
  logic [31:0] m_last  [16];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic cfg(input logic [3:0] f, input bit fr, input bit sm, input logic [23:0] inc,
                     input logic [31:0] seed);
    cfg_we = 1'b1; cfg_flow = f; cfg_frame = fr; cfg_smooth = sm; cfg_incr = inc; cfg_seed = seed;
    m_frame[f] = fr; m_smooth[f] = sm; m_incr[f] = inc; m_last[f] = seed;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic [3:0] f, input logic [15:0] len, input logic [31:0] now,
                      input logic [7:0] parts, input string tag);
    logic [31:0] inc, base;
    logic [39:0] prod;
    int          d;
    exp_t        e;
    d    = (parts == 0) ? 1 : int'(parts);
    prod = 40'(len) * 40'(m_incr[f]);
    inc  = m_frame[f] ? 32'(int'(m_incr[f]) / d) : prod[31:0];
    base = ($signed(now - m_last[f]) > 0) ? now : m_last[f];
    e.flow = f; e.dl = base + inc; e.sm = m_smooth[f]; e.tag = tag;
    m_last[f] = e.dl;
    exp_q.push_back(e);
    req_valid = 1'b1; req_flow = f; req_len = len; req_now = now; req_parts = parts;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic probe(input bit sm, input logic [31:0] dl, input logic [31:0] now,
                       input bit expv, input string tag);
    chk_smooth = sm; chk_deadline = dl; chk_now = now;
    #1;
    check(chk_ok == expv, tag, 32'(chk_ok), 32'(expv));
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected response", rsp_deadline, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rsp_deadline == e.dl, {e.tag, " deadline"}, rsp_deadline, e.dl);
        check(rsp_eligible == e.dl - 32'(EF), "R5 eligible", rsp_eligible, e.dl - 32'(EF));
        check(rsp_flow == e.flow && rsp_smooth == e.sm, "R5 flow/smooth",
              {27'd0, rsp_smooth, rsp_flow}, {27'd0, e.sm, e.flow});
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_frame[i] = 0; m_smooth[i] = 0; m_incr[i] = '0; m_last[i] = '0;
    end
    rst_n = 1'b0; cfg_we = 0; cfg_flow = 0; cfg_frame = 0; cfg_smooth = 0;
    cfg_incr = 0; cfg_seed = 0; req_valid = 0; req_flow = 0; req_len = 0;
    req_now = 0; req_parts = 0; chk_now = 0; chk_deadline = 0; chk_smooth = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);

    // R1: unconfigured entry starts at zero last deadline, zero increment
    send(4'd0, 16'd10, 32'd50, 8'd0, "R1 reset entry");

    // R2 R3 R10: rate mode, back-to-back chaining
    cfg(4'd1, 1'b0, 1'b1, 24'd4, 32'd0);
    send(4'd1, 16'd8, 32'd100, 8'd0, "R2 rate");
    send(4'd1, 16'd2, 32'd101, 8'd0, "R10 back-to-back");
    send(4'd1, 16'd1, 32'd500, 8'd0, "R3 now later");

    // R4: frame mode shares the target
    cfg(4'd2, 1'b1, 1'b0, 24'd1000, 32'd0);
    send(4'd2, 16'd2048, 32'd10, 8'd40, "R4 frame 40");
    send(4'd2, 16'd100, 32'd11, 8'd3, "R4 frame 3");
    send(4'd2, 16'd100, 32'd12, 8'd0, "R4 parts zero");

    // R2: control flow at link rate
    cfg(4'd3, 1'b0, 1'b0, 24'd1, 32'd0);
    send(4'd3, 16'd64, 32'd200, 8'd0, "R2 control");

    // R7: wrap-safe base selection
    cfg(4'd4, 1'b0, 1'b1, 24'd1, 32'hFFFF_FFF0);
    send(4'd4, 16'd5, 32'h0000_0010, 8'd0, "R7 wrap now later");
    send(4'd4, 16'd5, 32'h0000_0008, 8'd0, "R7 wrap last later");

    // R8: writing another entry leaves flow 1 intact
    cfg(4'd5, 1'b1, 1'b1, 24'd77, 32'd9000);
    send(4'd1, 16'd1, 32'd505, 8'd0, "R8 other entry kept");

    // R9: write on the update edge of the same flow
    send(4'd1, 16'd1, 32'd600, 8'd0, "R9 response before collision");
    cfg(4'd1, 1'b0, 1'b1, 24'd4, 32'd5000);
    send(4'd1, 16'd1, 32'd700, 8'd0, "R9 seed wins");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all responses seen", 32'(exp_q.size()), 32'h0);

    // R6: eligibility probe
    probe(1'b1, 32'd100, 32'd79,  1'b0, "R6 too early");
    probe(1'b1, 32'd100, 32'd80,  1'b1, "R6 exact boundary");
    probe(1'b1, 32'd100, 32'd120, 1'b1, "R6 late");
    probe(1'b0, 32'd100, 32'd0,   1'b1, "R6 not smoothed");
    probe(1'b1, 32'd5, 32'hFFFF_FFF5, 1'b1, "R6 R7 wrap ok");
    probe(1'b1, 32'd5, 32'hFFFF_FFF0, 1'b0, "R6 R7 wrap early");

    finish_run();
  end
endmodule